// File: doc/BRIEF.md
# Internal Data Memory Access Controller

This block sits between a byte-oriented processor core and its 256-byte on-chip scratch RAM. It also steers accesses to a separate 128-byte special-function-register (SFR) window. The upper half of the address space is shared. A direct byte access to 0x80–0xFF goes out on the SFR bus. An indirect byte access to the same addresses reaches RAM. The lower half is the same RAM for both modes.

Besides plain byte accesses, the controller resolves two other kinds of access. A register access is relative to a bank. A single-bit access reads, sets or clears one bit of the bit-addressable bytes, or forwards an upper bit address to the SFR bus as a bit cycle. Read data comes back registered on the cycle after the strobe. SFR requests are presented in the strobe cycle, so a combinational SFR responder can answer them.

Top module: `idata_ctrl`

## Requirements
- R1: While `rst` is high, `rvalid` and `rdata` are 0 after each clock edge.
- R2: Access kind code on `req_kind` is 2'b00 for byte, 2'b01 for bit and 2'b10 for register; 2'b11 acts as byte. A byte access to 0x00–0x7F in either mode, or an indirect byte access (`req_indirect`=1) to any address, reads and writes RAM byte `req_addr`; both modes reach the same byte below 0x80.
- R3: A direct byte access (`req_indirect`=0) to 0x80–0xFF raises `sfr_rd` or `sfr_wr` in the strobe cycle, with `sfr_addr`=`req_addr`, `sfr_bit`=0 and `sfr_wdata`=`req_wdata`. A read returns `sfr_rdata`, and the RAM is left unchanged.
- R4: A register access reaches RAM byte `bank_sel`*8 + `req_addr[2:0]`, whatever `req_indirect` and the upper address bits are, and never raises an SFR strobe.
- R5: A bit access with `req_addr` below 0x80 addresses RAM byte 0x20 + `req_addr[6:3]`, bit `req_addr[2:0]`. A bit read returns that bit in `rdata[0]`, with `rdata[7:1]`=0.
- R6: A bit write to RAM stores `req_wdata[0]` in the selected bit and leaves the other seven bits of that byte unchanged.
- R7: A bit access with `req_addr` at 0x80 or above is sent to the SFR bus with `sfr_bit`=1 and `sfr_addr`=`req_addr`, whatever `req_indirect` is. It leaves RAM untouched, and a read returns `sfr_rdata[0]` in `rdata[0]` with the upper bits 0.
- R8: `rvalid` is 1 exactly on the cycle after a read strobe, and `rdata` holds the value read. A read in the cycle right after a write to the same location returns the new value.
- R9: When `req_rd` and `req_wr` are both high, only the write is performed: no `sfr_rd`, and `rvalid` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_kind | input | 2 | Access kind: byte, bit or register |
| req_indirect | input | 1 | 1 = indirect addressing, 0 = direct |
| req_addr | input | 8 | Byte, bit or register-index address |
| bank_sel | input | 2 | Register bank select |
| req_wdata | input | 8 | Write data (bit value in bit 0 for bit writes) |
| rdata | output | 8 | Registered read data |
| rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| sfr_rd | output | 1 | SFR bus read request |
| sfr_wr | output | 1 | SFR bus write request |
| sfr_bit | output | 1 | SFR request is a single-bit access |
| sfr_addr | output | 8 | SFR bus address |
| sfr_wdata | output | 8 | SFR bus write data |
| sfr_rdata | input | 8 | SFR bus read data, sampled in the strobe cycle |

## Verification
The RAM is first filled through indirect byte writes. Random mixes of kind, mode, address, bank and strobes then run against a byte-array model and an SFR stub whose read data is a fixed function of the address. This separates RAM hits from SFR hits in the upper half, and a wrong bank or bit-byte mapping shows up as data read from the wrong byte. Directed cases cover four things: the same upper address written in both modes and then read indirectly, a bit write between byte reads to expose a clobbered neighbour bit, a back-to-back write then read, and simultaneous strobes.

// File: rtl/idata_pkg.sv
package idata_pkg;
  typedef enum logic [1:0] {
    KIND_BYTE = 2'b00,
    KIND_BIT  = 2'b01,
    KIND_REG  = 2'b10,
    KIND_RSVD = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/idata_decode.sv
module idata_decode
  import idata_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BANK_W   = 2,
  parameter int REG_W    = 3,
  parameter int BIT_W    = 3,
  parameter int BIT_BASE = 32
) (
  input  logic [1:0]        kind,
  input  logic              indirect,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [BIT_W-1:0]  bit_idx,
  output logic              is_bit,
  output logic              is_sfr
);
  localparam int REGB_W = BANK_W + REG_W;
  localparam int BOFS_W = ADDR_W - 1 - BIT_W;

  always_comb begin
    ram_addr = addr;
    bit_idx  = addr[BIT_W-1:0];
    is_bit   = 1'b0;
    is_sfr   = 1'b0;
    case (acc_kind_e'(kind))
      KIND_BIT: begin
        is_bit = 1'b1;
        if (addr[ADDR_W-1]) begin
          is_sfr = 1'b1;
        end else begin
          ram_addr = ADDR_W'(BIT_BASE) +
                     ADDR_W'(addr[ADDR_W-2 -: BOFS_W]);
        end
      end
      KIND_REG: begin
        ram_addr = ADDR_W'({bank, addr[REG_W-1:0]});
      end
      default: begin
        is_sfr = addr[ADDR_W-1] & ~indirect;
      end
    endcase
  end

  logic unused_w;
  assign unused_w = ^REGB_W;
endmodule

// File: rtl/idata_ram.sv
module idata_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic              we_bit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_byte
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] merged;

  assign rd_byte = mem[addr];

  always_comb begin
    merged = rd_byte;
    merged[bit_idx] = wdata[0];
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= we_bit ? merged : wdata;
  end
endmodule

// File: rtl/idata_rdstage.sv
module idata_rdstage #(
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              do_read,
  input  logic              is_sfr,
  input  logic              is_bit,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic [DATA_W-1:0] ram_byte,
  input  logic [DATA_W-1:0] sfr_byte,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    src = is_sfr ? sfr_byte : ram_byte;
    nxt = src;
    if (is_bit) nxt = DATA_W'(is_sfr ? sfr_byte[0] : ram_byte[bit_idx]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= do_read;
      if (do_read) rdata <= nxt;
    end
  end
endmodule

// File: rtl/idata_ctrl.sv
module idata_ctrl
  import idata_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int BANK_W   = 2,
  parameter int REG_W    = 3,
  parameter int BIT_BASE = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [1:0]        req_kind,
  input  logic              req_indirect,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              sfr_rd,
  output logic              sfr_wr,
  output logic              sfr_bit,
  output logic [ADDR_W-1:0] sfr_addr,
  output logic [DATA_W-1:0] sfr_wdata,
  input  logic [DATA_W-1:0] sfr_rdata
);
  localparam int BIT_W = $clog2(DATA_W);

  logic [ADDR_W-1:0] ram_addr;
  logic [BIT_W-1:0]  bit_idx;
  logic              is_bit;
  logic              is_sfr;
  logic [DATA_W-1:0] ram_byte;
  logic              do_read;

  idata_decode #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .REG_W(REG_W),
    .BIT_W(BIT_W), .BIT_BASE(BIT_BASE)
  ) u_dec (
    .kind(req_kind), .indirect(req_indirect), .addr(req_addr),
    .bank(bank_sel), .ram_addr(ram_addr), .bit_idx(bit_idx),
    .is_bit(is_bit), .is_sfr(is_sfr)
  );

  idata_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_W(BIT_W)) u_ram (
    .clk(clk), .we(req_wr & ~is_sfr), .we_bit(is_bit), .addr(ram_addr),
    .bit_idx(bit_idx), .wdata(req_wdata), .rd_byte(ram_byte)
  );

  assign do_read = req_rd & ~req_wr;

  idata_rdstage #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_rd (
    .clk(clk), .rst(rst), .do_read(do_read), .is_sfr(is_sfr),
    .is_bit(is_bit), .bit_idx(bit_idx), .ram_byte(ram_byte),
    .sfr_byte(sfr_rdata), .rdata(rdata), .rvalid(rvalid)
  );

  assign sfr_rd    = do_read & is_sfr;
  assign sfr_wr    = req_wr & is_sfr;
  assign sfr_bit   = is_bit & is_sfr;
  assign sfr_addr  = req_addr;
  assign sfr_wdata = req_wdata;
endmodule

// File: rtl/idata_ctrl_chk.sv
module idata_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_rd,
  input logic              req_wr,
  input logic [1:0]        req_kind,
  input logic              req_indirect,
  input logic [ADDR_W-1:0] req_addr,
  input logic [BANK_W-1:0] bank_sel,
  input logic [DATA_W-1:0] req_wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              rvalid,
  input logic              sfr_rd,
  input logic              sfr_wr,
  input logic              sfr_bit,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic [DATA_W-1:0] sfr_wdata,
  input logic [DATA_W-1:0] sfr_rdata
);
  a_r2_low_byte_stays_ram: assert property (@(posedge clk) disable iff (rst)
    (req_kind != 2'b01 && req_kind != 2'b10 && !req_addr[ADDR_W-1])
      |-> (!sfr_rd && !sfr_wr));

  a_r3_direct_upper_to_sfr: assert property (@(posedge clk) disable iff (rst)
    (req_rd && !req_wr && req_kind != 2'b01 && req_kind != 2'b10 &&
     !req_indirect && req_addr[ADDR_W-1]) |-> (sfr_rd && !sfr_bit && sfr_addr == req_addr));

  a_r4_reg_never_sfr: assert property (@(posedge clk) disable iff (rst)
    (req_kind == 2'b10) |-> (!sfr_rd && !sfr_wr));

  a_r5_bit_read_shape: assert property (@(posedge clk) disable iff (rst)
    (req_rd && !req_wr && req_kind == 2'b01) |=> (rdata[DATA_W-1:1] == '0));

  a_r7_upper_bit_to_sfr: assert property (@(posedge clk) disable iff (rst)
    (req_wr && req_kind == 2'b01 && req_addr[ADDR_W-1]) |-> (sfr_wr && sfr_bit && sfr_wdata == req_wdata));

  a_r8_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
    (req_rd && !req_wr) |=> rvalid);

  a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
    (req_rd && req_wr) |-> !sfr_rd);

  a_r9_no_rvalid: assert property (@(posedge clk) disable iff (rst)
    !(req_rd && !req_wr) |=> !rvalid);

  logic unused_c;
  assign unused_c = ^{bank_sel, sfr_rdata};
endmodule

bind idata_ctrl idata_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)
) u_chk (.*);

// File: tb/idata_ctrl_bench.sv
module idata_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       req_rd, req_wr, req_indirect;
  logic [1:0] req_kind, bank_sel;
  logic [7:0] req_addr, req_wdata;
  logic [7:0] rdata, sfr_addr, sfr_wdata, sfr_rdata;
  logic       rvalid, sfr_rd, sfr_wr, sfr_bit;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;
  logic [7:0] model [256];

  always #2 clk = ~clk;

  assign sfr_rdata = sfr_addr ^ 8'h3C;  // SFR stub

  idata_ctrl u_idata_ctrl (
    .clk(clk), .rst(rst), .req_rd(req_rd), .req_wr(req_wr),
    .req_kind(req_kind), .req_indirect(req_indirect), .req_addr(req_addr),
    .bank_sel(bank_sel), .req_wdata(req_wdata), .rdata(rdata),
    .rvalid(rvalid), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr), .sfr_bit(sfr_bit),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit to_sfr(logic [1:0] k, logic ind, logic [7:0] a);
    if (k == 2'b10) return 1'b0;
    if (k == 2'b01) return a[7];
    return a[7] & ~ind;
  endfunction

  function automatic logic [7:0] ram_idx(logic [1:0] k, logic [7:0] a, logic [1:0] b);
    if (k == 2'b10) return {3'b000, b, a[2:0]};
    if (k == 2'b01) return 8'h20 + {4'h0, a[6:3]};
    return a;
  endfunction

  task automatic op(string tag, logic rd, logic wr, logic [1:0] k, logic ind,
                    logic [7:0] a, logic [1:0] b, logic [7:0] wd);
    bit s;
    logic [7:0] ix, e;
    req_rd = rd; req_wr = wr; req_kind = k; req_indirect = ind;
    req_addr = a; bank_sel = b; req_wdata = wd;
    #1;
    s  = to_sfr(k, ind, a);
    ix = ram_idx(k, a, b);
    chk(tag, "sfr_rd", sfr_rd, rd && !wr && s);
    chk(tag, "sfr_wr", sfr_wr, wr && s);
    if (s && (rd || wr)) begin
      chk(tag, "sfr_addr", sfr_addr, a);
      chk(tag, "sfr_bit", sfr_bit, k == 2'b01);
      if (wr) chk(tag, "sfr_wdata", sfr_wdata, wd);
    end
    if (s) e = (k == 2'b01) ? {7'd0, (a[0] ^ 1'b0)} : (a ^ 8'h3C);
    else if (k == 2'b01) e = {7'd0, model[ix][a[2:0]]};
    else e = model[ix];
    if (wr && !s) begin
      if (k == 2'b01) model[ix][a[2:0]] = wd[0];
      else model[ix] = wd;
    end
    @(negedge clk);
    chk(tag, "rvalid", rvalid, rd && !wr);
    if (rd && !wr) chk(tag, "rdata", rdata, e);
  endtask

  task automatic idle();
    req_rd = 0; req_wr = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; req_rd = 0; req_wr = 0; req_kind = 0; req_indirect = 0;
    req_addr = 0; bank_sel = 0; req_wdata = 0;
    repeat (3) @(negedge clk);
    chk("R1", "rvalid in reset", rvalid, 0);
    chk("R1", "rdata in reset", rdata, 0);
    rst = 0;
    @(negedge clk);
    // R2: fill RAM indirectly
    for (int i = 0; i < 256; i++) op("R2", 0, 1, 2'b00, 1, 8'(i), 0, 8'(i * 7 + 3));
    idle();
    // R2: low half same byte in both modes
    op("R2", 0, 1, 2'b00, 0, 8'h41, 0, 8'h66);
    op("R2", 1, 0, 2'b00, 1, 8'h41, 0, 8'h00);
    // R3: upper direct goes to SFR, RAM kept
    op("R2", 0, 1, 2'b00, 1, 8'h90, 0, 8'h11);
    op("R3", 0, 1, 2'b00, 0, 8'h90, 0, 8'h77);
    op("R3", 1, 0, 2'b00, 0, 8'h90, 0, 8'h00);
    op("R3", 1, 0, 2'b00, 1, 8'h90, 0, 8'h00);
    // R4: register banks
    op("R4", 0, 1, 2'b10, 0, 8'hF5, 2'd3, 8'hC3);
    op("R4", 1, 0, 2'b00, 1, 8'h1D, 0, 8'h00);
    // R6: bit write keeps neighbours
    op("R6", 0, 1, 2'b00, 0, 8'h25, 0, 8'hA5);
    op("R6", 0, 1, 2'b01, 0, 8'h2B, 0, 8'h01);
    op("R6", 1, 0, 2'b00, 0, 8'h25, 0, 8'h00);
    op("R5", 1, 0, 2'b01, 1, 8'h2D, 0, 8'h00);
    // R7: upper bit to SFR
    op("R7", 0, 1, 2'b01, 1, 8'hE3, 0, 8'h01);
    op("R7", 1, 0, 2'b01, 0, 8'hE3, 0, 8'h00);
    // R8: back-to-back write then read
    op("R8", 0, 1, 2'b00, 1, 8'hC0, 0, 8'h5E);
    op("R8", 1, 0, 2'b00, 1, 8'hC0, 0, 8'h00);
    // R9: both strobes
    op("R9", 1, 1, 2'b00, 1, 8'h33, 0, 8'h99);
    op("R9", 1, 0, 2'b00, 0, 8'h33, 0, 8'h00);
    idle();
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] k;
      logic rd, wr;
      string t;
      k  = 2'($urandom);
      rd = 1'($urandom);
      wr = ($urandom % 3) == 0;
      if (k == 2'b10) t = "R4";
      else if (k == 2'b01) t = ($urandom % 2) ? "R5" : "R7";
      else t = "R2";
      op(t, rd, wr, k, 1'($urandom), 8'($urandom), 2'($urandom), 8'($urandom));
      if ($urandom % 8 == 0) idle();
    end
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule